// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the core side of one coprocessor instruction. After a start pulse it offers the instruction to an attached coprocessor and waits for a reply. While the coprocessor reports busy, the block puts one idle cycle between offers. If an interrupt becomes pending during that wait, the block drops the instruction and tells the coprocessor so. If the coprocessor refuses the instruction, the block raises an undefined-instruction trap. The block handles five operations: a register move to the coprocessor, a register move from the coprocessor, a coprocessor-internal data operation, a load that feeds memory words to the coprocessor, and a store that writes coprocessor words to memory.

Loads and stores are post-indexed bursts. The first word uses the start address. Each further word uses the previous address plus four, and the burst goes on for as long as the coprocessor replies "more". The start address is checked before any handshake starts. A memory abort stops a burst that is running. Each instruction ends with a single-cycle `done` pulse that carries a status code and, for a dropped instruction, the class of interrupt that caused it.

Top module: `cpx_handshake_seq`

## Requirements
- R1: After reset `done`, `mem_req` and `status` are 0, and `cp_req` is NONE (0).
- R2: Call the start cycle 0. In cycle 1, `cp_req` is FIRST (1). Each busy reply (`cp_resp`=1) is followed by one cycle with `cp_req`=NONE and then a re-offer with `cp_req`=RETRY (2). A data operation (op=2) that is busy N times gives `done` in cycle 2+2N with status OK (0).
- R3: Suppose an interrupt is pending during the idle cycle after a busy reply. The next cycle then carries `cp_req`=QUIT (3), and `done` follows with status ABANDON (3). `irq_kind` gives the interrupt class: 1 reset, 2 fast, 3 normal.
- R4: The pending interrupt is chosen in this order: reset first, then fast if `fast_mask` is 0, then normal if `norm_mask` is 0. A masked request is not pending, and a run with no pending interrupt ends OK with `irq_kind` 0.
- R5: A refuse reply (`cp_resp`=2) to an offer gives `done` in the next cycle with status UNDEF (1).
- R6: When a move from the coprocessor (op=1) is refused, `rd_data` is set to the parameter UNDEF_RDATA (default 0xF000_0000). That value leaves the flags unchanged.
- R7: A move to the coprocessor (op=0) adds one cycle with `cp_req`=XFER (4) that carries `src_data` on `cp_wdata`, and `done` comes in cycle 3+2N. A move from the coprocessor (op=1) captures `cp_rdata` in its XFER cycle, adds one more idle cycle, and gives `done` in cycle 4+2N.
- R8: A load (op=3) or store (op=4) that is accepted runs one word per cycle with `cp_req`=DATA (5) and `mem_req`=1. Word k goes to start+4k. The burst holds K+1 words while the reply is MORE (3) K times, and `done` comes in cycle K+3. A load forwards `mem_rdata` to `cp_wdata`. A store sets `mem_we` and writes `cp_rdata`.
- R9: A load or store whose start address has any bit at or above LEGAL_AW set (default 26) is refused before any handshake. So is a store whose start address is below VEC_BYTES (default 32). Either case gives `done` in cycle 1 with status DABORT (2), and no coprocessor or memory request is made.
- R10: `mem_abort` during a burst word ends the burst after that word, and `done` follows with status DABORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only when the block is idle) |
| op | input | 3 | Operation: 0 move to, 1 move from, 2 data op, 3 load, 4 store |
| start_addr | input | AW | Start address for a load or store |
| src_data | input | DW | Core register value for a move to the coprocessor |
| rst_pend | input | 1 | Reset request |
| fast_pend | input | 1 | Fast interrupt request |
| norm_pend | input | 1 | Normal interrupt request |
| fast_mask | input | 1 | Blocks the fast interrupt when 1 |
| norm_mask | input | 1 | Blocks the normal interrupt when 1 |
| cp_req | output | 3 | Phase offered to the coprocessor |
| cp_resp | input | 3 | Coprocessor reply: 0 accept, 1 busy, 2 refuse, 3 more, 4 last |
| cp_wdata | output | DW | Data to the coprocessor |
| cp_rdata | input | DW | Data from the coprocessor |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (same cycle) |
| mem_abort | input | 1 | Memory abort for this cycle's access |
| done | output | 1 | Instruction finished (one cycle) |
| status | output | 2 | 0 OK, 1 UNDEF, 2 DABORT, 3 ABANDON |
| irq_kind | output | 2 | Interrupt class that dropped the instruction |
| rd_data | output | DW | Result of a move from the coprocessor |

## Verification
The hardest case to reach is the point where an interrupt drops an instruction. It only happens in the idle cycle between two busy replies, and it depends on both masks as well as all three requests. The bench model keeps the coprocessor busy for several offers while the interrupt inputs are held steady. It runs through all 32 combinations of the three requests and two masks, and for each one it computes the class that should win, or an ordinary completion. Bursts that are cut short need the memory model to abort at a chosen word, so the stimulus sets the abort address a fixed number of words past the start.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   typedef enum logic [2:0] {
      OP_TO_CP   = 3'd0,
      OP_FROM_CP = 3'd1,
      OP_DATA    = 3'd2,
      OP_LOAD    = 3'd3,
      OP_STORE   = 3'd4
   } cpx_op_e;

   typedef enum logic [2:0] {
      RQ_NONE  = 3'd0,
      RQ_FIRST = 3'd1,
      RQ_RETRY = 3'd2,
      RQ_QUIT  = 3'd3,
      RQ_XFER  = 3'd4,
      RQ_DATA  = 3'd5
   } cpx_req_e;

   typedef enum logic [2:0] {
      RS_ACCEPT = 3'd0,
      RS_BUSY   = 3'd1,
      RS_REFUSE = 3'd2,
      RS_MORE   = 3'd3,
      RS_LAST   = 3'd4
   } cpx_resp_e;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_UNDEF  = 2'd1,
      ST_DABORT = 2'd2,
      ST_QUIT   = 2'd3
   } cpx_stat_e;

   typedef enum logic [1:0] {
      IK_NONE  = 2'd0,
      IK_RESET = 2'd1,
      IK_FAST  = 2'd2,
      IK_NORM  = 2'd3
   } cpx_kind_e;

   typedef enum logic [2:0] {
      S_IDLE, S_ASK, S_PAUSE, S_QUIT, S_CCYC, S_ICYC, S_BURST, S_FIN
   } cpx_state_e;

endpackage

// File: rtl/cpx_irq_arb.sv
module cpx_irq_arb
   import cpx_pkg::*;
(
   input  logic      rst_pend,
   input  logic      fast_pend,
   input  logic      norm_pend,
   input  logic      fast_mask,
   input  logic      norm_mask,
   output logic      pend,
   output cpx_kind_e kind
);

   always_comb begin
      if (rst_pend)
         kind = IK_RESET;
      else if (fast_pend && !fast_mask)
         kind = IK_FAST;
      else if (norm_pend && !norm_mask)
         kind = IK_NORM;
      else
         kind = IK_NONE;
   end

   assign pend = (kind != IK_NONE);

endmodule

// File: rtl/cpx_addr_unit.sv
module cpx_addr_unit #(
   parameter int AW        = 32,
   parameter int LEGAL_AW  = 26,
   parameter int VEC_BYTES = 32,
   parameter int STEP      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] start_addr,
   input  logic          is_store,
   output logic [AW-1:0] cur_addr,
   output logic          bad
);

   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic range_bad;
   logic vec_bad;

   generate
      if (LEGAL_AW < AW) begin : g_range
         assign range_bad = |start_addr[AW-1:LEGAL_AW];
      end else begin : g_norange
         assign range_bad = 1'b0;
      end

      if (VEC_BYTES > 0) begin : g_vec
         assign vec_bad = (start_addr < AW'(VEC_BYTES));
      end else begin : g_novec
         assign vec_bad = 1'b0;
      end
   endgenerate

   assign bad = range_bad | (is_store & vec_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_addr <= '0;
      else if (load)
         cur_addr <= start_addr;
      else if (step)
         cur_addr <= cur_addr + STEP_V;
   end

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur_addr == $past(cur_addr) + STEP_V));

endmodule

// File: rtl/cpx_handshake_seq.sv
module cpx_handshake_seq
   import cpx_pkg::*;
#(
   parameter int             AW          = 32,
   parameter int             DW          = 32,
   parameter int             LEGAL_AW    = 26,
   parameter int             VEC_BYTES   = 32,
   parameter logic [DW-1:0]  UNDEF_RDATA = DW'(32'hF000_0000)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] src_data,
   input  logic          rst_pend,
   input  logic          fast_pend,
   input  logic          norm_pend,
   input  logic          fast_mask,
   input  logic          norm_mask,
   output logic [2:0]    cp_req,
   input  logic [2:0]    cp_resp,
   output logic [DW-1:0] cp_wdata,
   input  logic [DW-1:0] cp_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_abort,
   output logic          done,
   output logic [1:0]    status,
   output logic [1:0]    irq_kind,
   output logic [DW-1:0] rd_data
);

   localparam int WORD_BYTES = 4;

   generate
      if (AW < 4) begin : g_bad_aw
         $error("cpx_handshake_seq: AW must be at least 4");
      end
      if (LEGAL_AW > AW || LEGAL_AW < 2) begin : g_bad_legal
         $error("cpx_handshake_seq: LEGAL_AW must lie in 2..AW");
      end
      if (DW < 1) begin : g_bad_dw
         $error("cpx_handshake_seq: DW must be positive");
      end
   endgenerate

   cpx_state_e state, state_n;
   cpx_op_e    op_q;
   cpx_stat_e  stat_q, stat_n;
   cpx_kind_e  kind_q;
   cpx_kind_e  arb_kind;
   cpx_resp_e  resp;
   cpx_req_e   req;
   logic       retry_q;
   logic       pend;
   logic       addr_bad;
   logic       accept_start;
   logic       is_mem_in;
   logic       is_store_in;
   logic       step;
   logic [DW-1:0] wbuf_q;
   logic [AW-1:0] cur_addr;

   assign resp         = cpx_resp_e'(cp_resp);
   assign accept_start = (state == S_IDLE) && start;
   assign is_store_in  = (cpx_op_e'(op) == OP_STORE);
   assign is_mem_in    = (cpx_op_e'(op) == OP_LOAD) || is_store_in;

   cpx_irq_arb i_arb (
      .rst_pend  (rst_pend),
      .fast_pend (fast_pend),
      .norm_pend (norm_pend),
      .fast_mask (fast_mask),
      .norm_mask (norm_mask),
      .pend      (pend),
      .kind      (arb_kind)
   );

   assign step = (state == S_BURST) && !mem_abort && (resp == RS_MORE);

   cpx_addr_unit #(
      .AW        (AW),
      .LEGAL_AW  (LEGAL_AW),
      .VEC_BYTES (VEC_BYTES),
      .STEP      (WORD_BYTES)
   ) i_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept_start),
      .step       (step),
      .start_addr (start_addr),
      .is_store   (is_store_in),
      .cur_addr   (cur_addr),
      .bad        (addr_bad)
   );

   // next-state logic
   always_comb begin
      state_n = state;
      stat_n  = stat_q;
      unique case (state)
         S_IDLE: begin
            if (start) begin
               if (is_mem_in && addr_bad) begin
                  state_n = S_FIN;
                  stat_n  = ST_DABORT;
               end else begin
                  state_n = S_ASK;
                  stat_n  = ST_OK;
               end
            end
         end
         S_ASK: begin
            if (resp == RS_BUSY) begin
               state_n = S_PAUSE;
            end else if (resp == RS_REFUSE) begin
               state_n = S_FIN;
               stat_n  = ST_UNDEF;
            end else begin
               unique case (op_q)
                  OP_TO_CP, OP_FROM_CP: state_n = S_CCYC;
                  OP_LOAD, OP_STORE:    state_n = S_BURST;
                  default: begin
                     state_n = S_FIN;
                     stat_n  = ST_OK;
                  end
               endcase
            end
         end
         S_PAUSE: state_n = pend ? S_QUIT : S_ASK;
         S_QUIT: begin
            state_n = S_FIN;
            stat_n  = ST_QUIT;
         end
         S_CCYC: state_n = (op_q == OP_FROM_CP) ? S_ICYC : S_FIN;
         S_ICYC: state_n = S_FIN;
         S_BURST: begin
            if (mem_abort) begin
               state_n = S_FIN;
               stat_n  = ST_DABORT;
            end else if (resp != RS_MORE) begin
               state_n = S_FIN;
            end
         end
         S_FIN:   state_n = S_IDLE;
         default: state_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         stat_q  <= ST_OK;
         kind_q  <= IK_NONE;
         op_q    <= OP_DATA;
         retry_q <= 1'b0;
         wbuf_q  <= '0;
         rd_data <= '0;
      end else begin
         state  <= state_n;
         stat_q <= stat_n;
         if (accept_start) begin
            op_q    <= cpx_op_e'(op);
            wbuf_q  <= src_data;
            retry_q <= 1'b0;
            kind_q  <= IK_NONE;
         end
         if (state == S_PAUSE) begin
            retry_q <= 1'b1;
            if (pend)
               kind_q <= arb_kind;
         end
         if (state == S_ASK && resp == RS_REFUSE && op_q == OP_FROM_CP)
            rd_data <= UNDEF_RDATA;
         if (state == S_CCYC && op_q == OP_FROM_CP)
            rd_data <= cp_rdata;
      end
   end

   // output decode
   always_comb begin
      unique case (state)
         S_ASK:   req = retry_q ? RQ_RETRY : RQ_FIRST;
         S_QUIT:  req = RQ_QUIT;
         S_CCYC:  req = RQ_XFER;
         S_BURST: req = RQ_DATA;
         default: req = RQ_NONE;
      endcase
   end

   assign cp_req    = req;
   assign cp_wdata  = (state == S_CCYC) ? wbuf_q :
                      ((state == S_BURST && op_q == OP_LOAD) ? mem_rdata : '0);
   assign mem_req   = (state == S_BURST);
   assign mem_we    = (state == S_BURST) && (op_q == OP_STORE);
   assign mem_addr  = cur_addr;
   assign mem_wdata = mem_we ? cp_rdata : '0;
   assign done      = (state == S_FIN);
   assign status    = stat_q;
   assign irq_kind  = kind_q;

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cp_req == RQ_FIRST || cp_req == RQ_RETRY) && cp_resp == RS_BUSY)
      |=> (cp_req == RQ_NONE));

   // R3
   quit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req == RQ_QUIT) |=> (done && status == ST_QUIT));

   // R5
   refuse_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cp_req == RQ_FIRST || cp_req == RQ_RETRY) && cp_resp == RS_REFUSE)
      |=> (done && status == ST_UNDEF));

   // R9
   early_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_start && is_mem_in && addr_bad)
      |=> (done && status == ST_DABORT && !mem_req));

   // R10
   burst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_abort) |=> (done && status == ST_DABORT));

endmodule

// File: tb/test_cpx_handshake_seq.sv
module test_cpx_handshake_seq;
   import cpx_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] start_addr = '0;
   logic [31:0] src_data = '0;
   logic        rst_pend = 0, fast_pend = 0, norm_pend = 0;
   logic        fast_mask = 0, norm_mask = 0;
   logic [2:0]  cp_req;
   logic [2:0]  cp_resp;
   logic [31:0] cp_wdata;
   logic [31:0] cp_rdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_abort;
   logic        done;
   logic [1:0]  status, irq_kind;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;

   // coprocessor and memory model settings
   int          m_busy = 0;
   logic [2:0]  m_final = 3'd0;
   int          m_inc = 0;
   logic        abort_en = 1'b0;
   logic [31:0] abort_addr = '0;
   int          bcnt, icnt;

   // observations of one run
   int          cyc, n_busy_req, n_quit, n_first, n_xfer, n_words, n_any;
   logic [31:0] xfer_data;
   logic        seq_bad;

   always #10ns clk = ~clk;

   cpx_handshake_seq i_cpx_handshake_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .start_addr(start_addr),
      .src_data(src_data), .rst_pend(rst_pend), .fast_pend(fast_pend),
      .norm_pend(norm_pend), .fast_mask(fast_mask), .norm_mask(norm_mask),
      .cp_req(cp_req), .cp_resp(cp_resp), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_abort(mem_abort), .done(done), .status(status),
      .irq_kind(irq_kind), .rd_data(rd_data)
   );

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction

   assign mem_rdata = mem_val(mem_addr);
   assign mem_abort = abort_en && mem_req && (mem_addr == abort_addr);

   always_comb begin
      if (cp_req == 3'd1 || cp_req == 3'd2)
         cp_resp = (bcnt < m_busy) ? 3'd1 : m_final;
      else if (cp_req == 3'd5)
         cp_resp = (icnt < m_inc) ? 3'd3 : 3'd4;
      else
         cp_resp = 3'd0;
   end

   always @(posedge clk) begin
      if (start) begin
         bcnt <= 0;
         icnt <= 0;
      end else begin
         if (cp_req == 3'd1 || cp_req == 3'd2) bcnt <= bcnt + 1;
         if (cp_req == 3'd5) icnt <= icnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] wd);
      @(negedge clk);
      start = 1'b1; op = o; start_addr = a; src_data = wd;
      n_busy_req = 0; n_quit = 0; n_first = 0; n_xfer = 0; n_words = 0; n_any = 0;
      xfer_data = '0; seq_bad = 1'b0;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 200) begin
         if (cp_req != 3'd0) n_any++;
         if (cp_req == 3'd1) n_first++;
         if (cp_req == 3'd2) n_busy_req++;
         if (cp_req == 3'd3) n_quit++;
         if (cp_req == 3'd4) begin n_xfer++; xfer_data = cp_wdata; end
         if ((cp_req == 3'd1 || cp_req == 3'd2) && cp_resp == 3'd1) begin
            @(negedge clk); cyc++;
            if (cp_req != 3'd0) seq_bad = 1'b1;
            continue;
         end
         if (cp_req == 3'd5) begin
            if (!mem_req || mem_addr != a + 32'(4 * n_words)) seq_bad = 1'b1;
            if (o == 3'd3 && (mem_we || cp_wdata != mem_val(mem_addr))) seq_bad = 1'b1;
            if (o == 3'd4 && (!mem_we || mem_wdata != cp_rdata)) seq_bad = 1'b1;
            n_words++;
         end
         @(negedge clk); cyc++;
      end
   endtask

   initial begin
      #1000000ns;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done == 0 && mem_req == 0 && status == 0 && cp_req == 0, "R1 reset",
            {done, mem_req, status, cp_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 busy sweep on data operation
      for (int n = 0; n <= 5; n++) begin
         m_busy = n; m_final = 3'd0;
         run_op(3'd2, 0, 0);
         check(cyc == 2 + 2 * n && status == 0, "R2 busy timing", cyc, 2 + 2 * n);
         check(n_busy_req == n && n_first == 1 && !seq_bad, "R2 retry/gap",
               n_busy_req, n);
      end

      // R7 move to coprocessor
      for (int n = 0; n <= 2; n += 2) begin
         m_busy = n; m_final = 3'd0;
         run_op(3'd0, 0, 32'hCAFE_0000 + 32'(n));
         check(cyc == 3 + 2 * n && status == 0, "R7 to-cp timing", cyc, 3 + 2 * n);
         check(n_xfer == 1 && xfer_data == 32'hCAFE_0000 + 32'(n), "R7 to-cp data",
               xfer_data, 32'hCAFE_0000 + 32'(n));
      end

      // R7 move from coprocessor
      for (int n = 0; n <= 1; n++) begin
         m_busy = n; m_final = 3'd0; cp_rdata = 32'h1234_5670 + 32'(n);
         run_op(3'd1, 0, 0);
         check(cyc == 4 + 2 * n && status == 0, "R7 from-cp timing", cyc, 4 + 2 * n);
         check(rd_data == 32'h1234_5670 + 32'(n), "R7 from-cp data", rd_data,
               32'h1234_5670 + 32'(n));
      end

      // R5 refuse on data operation
      m_busy = 0; m_final = 3'd2;
      run_op(3'd2, 0, 0);
      check(cyc == 2 && status == 1, "R5 refuse", {cyc[29:0], status}, {30'd2, 2'd1});

      // R6 refuse on read after one busy reply
      m_busy = 1; m_final = 3'd2; cp_rdata = 32'h0BAD_0BAD;
      run_op(3'd1, 0, 0);
      check(cyc == 4 && status == 1, "R6 refuse timing", cyc, 4);
      check(rd_data == 32'hF000_0000, "R6 refuse data", rd_data, 32'hF000_0000);

      // R3 R4 exhaustive interrupt sweep during busy wait
      for (int v = 0; v < 32; v++) begin
         int k;
         rst_pend = v[0]; fast_pend = v[1]; norm_pend = v[2];
         fast_mask = v[3]; norm_mask = v[4];
         k = v[0] ? 1 : (v[1] && !v[3]) ? 2 : (v[2] && !v[4]) ? 3 : 0;
         m_busy = 3; m_final = 3'd0;
         run_op(3'd2, 0, 0);
         if (k != 0) begin
            check(cyc == 4 && status == 3 && n_quit == 1, "R3 abandon",
                  {cyc[29:0], status}, {30'd4, 2'd3});
            check(irq_kind == 2'(k), "R4 priority", irq_kind, k);
         end else begin
            check(cyc == 8 && status == 0 && n_quit == 0 && irq_kind == 0, "R4 masked",
                  cyc, 8);
         end
      end
      rst_pend = 0; fast_pend = 0; norm_pend = 0; fast_mask = 0; norm_mask = 0;

      // R8 load bursts
      for (int n = 1; n <= 4; n++) begin
         m_busy = n - 1; m_final = 3'd0; m_inc = n - 1;
         run_op(3'd3, 32'h100 + 32'(16 * n), 0);
         check(cyc == n + 2 + 2 * (n - 1) && status == 0, "R8 load timing", cyc,
               n + 2 + 2 * (n - 1));
         check(n_words == n && !seq_bad, "R8 load words", n_words, n);
      end

      // R8 store bursts
      for (int n = 1; n <= 3; n++) begin
         m_busy = 0; m_final = 3'd0; m_inc = n - 1; cp_rdata = 32'hC0DE_0000 + 32'(n);
         run_op(3'd4, 32'h40, 0);
         check(cyc == n + 2 && status == 0, "R8 store timing", cyc, n + 2);
         check(n_words == n && !seq_bad, "R8 store words", n_words, n);
      end

      // R9 address checks
      m_busy = 0; m_final = 3'd0; m_inc = 0;
      run_op(3'd3, 32'h0400_0000, 0);
      check(cyc == 1 && status == 2 && n_any == 0, "R9 range load",
            {cyc[29:0], status}, {30'd1, 2'd2});
      run_op(3'd4, 32'h1C, 0);
      check(cyc == 1 && status == 2 && n_any == 0, "R9 vector store",
            {cyc[29:0], status}, {30'd1, 2'd2});
      run_op(3'd4, 32'h20, 0);
      check(cyc == 3 && status == 0 && n_words == 1, "R9 store at limit", cyc, 3);
      run_op(3'd3, 32'h10, 0);
      check(cyc == 3 && status == 0 && n_words == 1, "R9 load low", cyc, 3);

      // R10 memory abort mid-burst
      m_inc = 5; abort_en = 1'b1; abort_addr = 32'h208;
      run_op(3'd3, 32'h200, 0);
      check(cyc == 5 && status == 2, "R10 abort timing", {cyc[29:0], status},
            {30'd5, 2'd2});
      check(n_words == 3 && !seq_bad, "R10 abort words", n_words, 3);
      abort_en = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule